// File: doc/BRIEF.md
# Adjustable PTP Hardware Clock

This block keeps a 64-bit time count for precision time protocol use. A 32-bit rate word is added to a 32-bit fractional accumulator on every core clock. Each carry out of the accumulator advances the time count by one tick, so the tick rate is linear in the rate word. Software trims frequency by rewriting the rate word and steps time by loading a new 64-bit value.

Two external trigger pins, called slave and master, each copy the current time into their own 64-bit capture pair on a falling edge. A 64-bit alarm comparator flags the moment time reaches a programmed value. The two capture flags and the alarm flag share one event register that is cleared by writing ones. A mask register selects which flags drive the interrupt output. Software reaches every register through a simple word-addressed read/write bus.

Top module: `ptp_hw_clock`

## Requirements
- R1: After reset the rate word reads the parameter default (0x4000_0000), the mask reads 0, the event register reads 0, time reads 0 and irq is low. Word map: 0 rate, 1 time low, 2 time high, 3 alarm low, 4 alarm high, 5 event, 6 mask, 7/8 slave capture low/high, 9/10 master capture low/high.
- R2: Each clock adds the rate word to the 32-bit accumulator, and time rises by one on each carry out of bit 31. A rate word of 0 freezes time, and the tick rate scales linearly with the rate word. A time load clears the accumulator.
- R3: A bus read of time low copies the current time high into a shadow register. A later read of time high returns that shadow, even if the live count has since carried into the high half.
- R4: A write to time low is only buffered and does not change time. A write to time high loads {written high, buffered low} into the time count as one 64-bit value.
- R5: A falling edge on a trigger pin, after a two-flop synchronizer, copies time into that pin's capture pair. It also sets event bit 0 for the slave pin or event bit 1 for the master pin.
- R6: While a channel's event bit is set, further falling edges on its pin leave its capture pair unchanged.
- R7: A rising edge on a trigger pin captures nothing and sets no event bit.
- R8: Event bit 2 (alarm pending) sets when time goes from below the alarm value to at or above it. It stays set until cleared. The alarm pair resets to all ones.
- R9: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: irq is high exactly when some event bit is set together with the mask bit at the same position. The mask holds bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, qualifies side effects of a read |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| trig_slave_n | input | 1 | Slave capture trigger, falling edge active |
| trig_master_n | input | 1 | Master capture trigger, falling edge active |
| irq | output | 1 | Masked OR of the event bits |

## Verification
The bench lets time carry from the low half into the high half between a low read and a high read. A clock without the shadow would return a torn 64-bit value there. It writes only the low half and checks that time has not moved, which catches a load that fires too early. It fires a second trigger while the first capture is still unserviced and expects the old capture to survive. It also raises a pin on its own and expects no capture, which would expose an edge detector of the wrong polarity. It clears the alarm while time still sits past the target and expects the flag to stay clear, which a level-sensitive comparator would fail. Writes of zeros to the event register must leave set flags alone.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int TIME_W = 2 * DATA_W;
    localparam int N_EVT  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_RATE     = 4'd0,
        A_TIME_LO  = 4'd1,
        A_TIME_HI  = 4'd2,
        A_ALARM_LO = 4'd3,
        A_ALARM_HI = 4'd4,
        A_EVENT    = 4'd5,
        A_MASK     = 4'd6,
        A_SCAP_LO  = 4'd7,
        A_SCAP_HI  = 4'd8,
        A_MCAP_LO  = 4'd9,
        A_MCAP_HI  = 4'd10
    } reg_addr_e;

    // bit positions are software visible
    typedef struct packed {
        logic alarm;
        logic cap_master;
        logic cap_slave;
    } evt_t;

    function automatic logic [DATA_W-1:0] lo_half(input logic [TIME_W-1:0] t);
        return t[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] hi_half(input logic [TIME_W-1:0] t);
        return t[TIME_W-1:DATA_W];
    endfunction

endpackage

// File: rtl/ptp_time_core.sv
module ptp_time_core #(
    parameter int ACC_W  = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  rate,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] sys_time
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, rate};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            sys_time <= '0;
        end else if (load) begin
            acc      <= '0;
            sys_time <= load_val;
        end else begin
            acc <= sum[ACC_W-1:0];
            if (sum[ACC_W]) sys_time <= sys_time + 1'b1;
        end
    end

    // R2: without a load, time moves by zero or one tick per clock
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> (sys_time == $past(sys_time) || sys_time == $past(sys_time) + 1'b1));

endmodule

// File: rtl/ptp_snap_chan.sv
module ptp_snap_chan #(
    parameter int TIME_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              clr,
    output logic              flag,
    output logic [TIME_W-1:0] snap
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   fall;
    logic                   take;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_n};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
    assign take = fall & ~flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            snap <= '0;
        end else if (take) begin
            flag <= 1'b1;
            snap <= sys_time;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R6: a pending capture is never overwritten
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        flag |=> $stable(snap));

    // R5: a new flag comes with the time of the capture cycle
    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> snap == $past(sys_time));

endmodule

// File: rtl/ptp_alarm_cmp.sv
module ptp_alarm_cmp #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] sys_time,
    input  logic [TIME_W-1:0] target,
    input  logic              clr,
    output logic              pending
);
    logic reached;
    logic reached_q;

    assign reached = (sys_time >= target);

    always_ff @(posedge clk) begin
        if (rst) begin
            reached_q <= 1'b0;
            pending   <= 1'b0;
        end else begin
            reached_q <= reached;
            if (reached && !reached_q) pending <= 1'b1;
            else if (clr)              pending <= 1'b0;
        end
    end

    // R8: pending stays until software clears it
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        pending && !clr |=> pending);

endmodule

// File: rtl/ptp_hw_clock.sv
module ptp_hw_clock
    import ptp_clk_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEF_RATE    = 32'h4000_0000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig_slave_n,
    input  logic              trig_master_n,
    output logic              irq
);
    localparam int N_CH = 2;

    logic [DATA_W-1:0] rate_q;
    logic [DATA_W-1:0] lo_buf;
    logic [DATA_W-1:0] hi_shadow;
    logic [TIME_W-1:0] alarm_q;
    logic [N_EVT-1:0]  mask_q;
    logic [TIME_W-1:0] sys_time;
    logic              load;
    logic [TIME_W-1:0] load_val;
    logic [N_EVT-1:0]  evt_clr;
    evt_t              evt;

    logic [N_CH-1:0]   ch_trig_n;
    logic [N_CH-1:0]   ch_flag;
    logic [TIME_W-1:0] ch_snap [N_CH];

    reg_addr_e addr;
    assign addr = reg_addr_e'(bus_addr);

    assign load     = bus_wr && (addr == A_TIME_HI);
    assign load_val = {bus_wdata, lo_buf};
    assign evt_clr  = (bus_wr && addr == A_EVENT) ? bus_wdata[N_EVT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q    <= DEF_RATE;
            lo_buf    <= '0;
            hi_shadow <= '0;
            alarm_q   <= '1;
            mask_q    <= '0;
        end else begin
            if (bus_rd && addr == A_TIME_LO) hi_shadow <= hi_half(sys_time);
            if (bus_wr) begin
                case (addr)
                    A_RATE:     rate_q                  <= bus_wdata;
                    A_TIME_LO:  lo_buf                  <= bus_wdata;
                    A_ALARM_LO: alarm_q[DATA_W-1:0]     <= bus_wdata;
                    A_ALARM_HI: alarm_q[TIME_W-1:DATA_W] <= bus_wdata;
                    A_MASK:     mask_q                  <= bus_wdata[N_EVT-1:0];
                    default: ;
                endcase
            end
        end
    end

    ptp_time_core #(.ACC_W(DATA_W), .TIME_W(TIME_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .rate     (rate_q),
        .load     (load),
        .load_val (load_val),
        .sys_time (sys_time)
    );

    assign ch_trig_n = {trig_master_n, trig_slave_n};

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        ptp_snap_chan #(.TIME_W(TIME_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .trig_n   (ch_trig_n[i]),
            .sys_time (sys_time),
            .clr      (evt_clr[i]),
            .flag     (ch_flag[i]),
            .snap     (ch_snap[i])
        );
    end

    ptp_alarm_cmp #(.TIME_W(TIME_W)) u_alarm (
        .clk      (clk),
        .rst      (rst),
        .sys_time (sys_time),
        .target   (alarm_q),
        .clr      (evt_clr[2]),
        .pending  (evt.alarm)
    );

    assign evt.cap_slave  = ch_flag[0];
    assign evt.cap_master = ch_flag[1];

    assign irq = |(evt & mask_q);

    always_comb begin
        case (addr)
            A_RATE:     bus_rdata = rate_q;
            A_TIME_LO:  bus_rdata = lo_half(sys_time);
            A_TIME_HI:  bus_rdata = hi_shadow;
            A_ALARM_LO: bus_rdata = lo_half(alarm_q);
            A_ALARM_HI: bus_rdata = hi_half(alarm_q);
            A_EVENT:    bus_rdata = {{(DATA_W-N_EVT){1'b0}}, evt};
            A_MASK:     bus_rdata = {{(DATA_W-N_EVT){1'b0}}, mask_q};
            A_SCAP_LO:  bus_rdata = lo_half(ch_snap[0]);
            A_SCAP_HI:  bus_rdata = hi_half(ch_snap[0]);
            A_MCAP_LO:  bus_rdata = lo_half(ch_snap[1]);
            A_MCAP_HI:  bus_rdata = hi_half(ch_snap[1]);
            default:    bus_rdata = '0;
        endcase
    end

    // R4: a high-half write loads both halves in one step
    assert_atomic_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> sys_time == {$past(bus_wdata), $past(lo_buf)});

    // R9: writing zero to a set event bit keeps it
    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        bus_wr && addr == A_EVENT && !bus_wdata[0] && evt.cap_slave |=> evt.cap_slave);

    // R10: no interrupt while every mask bit is clear
    assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

endmodule

// File: tb/ptp_hw_clock_tb.sv
module ptp_hw_clock_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trig_slave_n = 1'b1;
    logic        trig_master_n = 1'b1;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ptp_hw_clock u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .trig_slave_n  (trig_slave_n),
        .trig_master_n (trig_master_n),
        .irq           (irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input logic [63:0] act,
                             input logic [63:0] lo, input logic [63:0] hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rd(4'd1, lo);
        rd(4'd2, hi);
        t = {hi, lo};
    endtask

    task automatic load_time(input logic [63:0] t);
        wr(4'd1, t[31:0]);
        wr(4'd2, t[63:32]);
    endtask

    task automatic pulse(input bit master, input bit level);
        @(negedge clk);
        if (master) trig_master_n = level; else trig_slave_n = level;
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'd0, d); check("R1 rate default", d, 32'h4000_0000);
        rd(4'd6, d); check("R1 mask", d, 0);
        rd(4'd5, d); check("R1 event", d, 0);
        rd(4'd1, d); rd(4'd2, d); check("R1 time high", d, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_load;
        logic [63:0] t0, t;
        wr(4'd0, 32'd0);
        rd_time(t0);
        wr(4'd1, 32'hDEAD_BEEF);
        repeat (3) @(posedge clk);
        rd_time(t); check("R4 low write buffered", t, t0);
        wr(4'd2, 32'h1234_5678);
        rd_time(t); check("R4 atomic load", t, 64'h1234_5678_DEAD_BEEF);
        rd_time(t); check("R2 rate zero freezes", t, 64'h1234_5678_DEAD_BEEF);
    endtask

    task automatic t_shadow;
        logic [31:0] lo, hi;
        wr(4'd0, 32'hFFFF_FFFF);
        load_time(64'h0000_0001_FFFF_FFF0);
        rd(4'd1, lo);
        check_rng("R3 low before carry", lo, 64'hFFFF_FFF0, 64'hFFFF_FFFF);
        repeat (40) @(posedge clk);
        rd(4'd2, hi); check("R3 high from shadow", hi, 32'h1);
        rd(4'd1, lo);
        rd(4'd2, hi); check("R3 high after new low read", hi, 32'h2);
    endtask

    task automatic t_rate;
        logic [31:0] lo;
        wr(4'd0, 32'h4000_0000);
        load_time(64'd0);
        repeat (400) @(posedge clk);
        rd(4'd1, lo); check_rng("R2 quarter rate", lo, 99, 101);
        wr(4'd0, 32'h2000_0000);
        load_time(64'd0);
        repeat (400) @(posedge clk);
        rd(4'd1, lo); check_rng("R2 eighth rate", lo, 49, 51);
        wr(4'd0, 32'd0);
    endtask

    task automatic t_slave;
        logic [31:0] d;
        load_time(64'h0000_00AB_0000_1234);
        pulse(0, 0);
        rd(4'd5, d); check("R5 slave event bit", d, 32'h1);
        rd(4'd7, d); check("R5 slave capture low", d, 32'h0000_1234);
        rd(4'd8, d); check("R5 slave capture high", d, 32'h0000_00AB);
        check("R10 masked irq low", irq, 0);
        pulse(0, 1);
        load_time(64'h0000_0001_0000_0002);
        pulse(0, 0);
        rd(4'd7, d); check("R6 capture held", d, 32'h0000_1234);
        wr(4'd6, 32'h1);
        check("R10 irq with mask", irq, 1);
        wr(4'd6, 32'h0);
        wr(4'd5, 32'h6);
        rd(4'd5, d); check("R9 zero write keeps bit", d, 32'h1);
        wr(4'd5, 32'h1);
        rd(4'd5, d); check("R9 one write clears", d, 32'h0);
        pulse(0, 1);
        pulse(0, 0);
        rd(4'd7, d); check("R5 recapture low", d, 32'h0000_0002);
        rd(4'd8, d); check("R5 recapture high", d, 32'h0000_0001);
        wr(4'd5, 32'h1);
        pulse(0, 1);
    endtask

    task automatic t_master;
        logic [31:0] d;
        load_time(64'h0000_0007_0000_0077);
        pulse(1, 0);
        rd(4'd5, d); check("R5 master event bit", d, 32'h2);
        rd(4'd9, d); check("R5 master capture low", d, 32'h0000_0077);
        wr(4'd5, 32'h2);
        load_time(64'h0000_0009_0000_0099);
        pulse(1, 1);
        rd(4'd5, d); check("R7 rising edge no event", d, 32'h0);
        rd(4'd9, d); check("R7 rising edge no capture", d, 32'h0000_0077);
    endtask

    task automatic t_alarm;
        logic [31:0] d;
        load_time(64'h100);
        wr(4'd4, 32'h0);
        wr(4'd3, 32'h105);
        wr(4'd6, 32'h4);
        rd(4'd5, d); check("R8 below target", d, 32'h0);
        check("R10 irq idle", irq, 0);
        load_time(64'h105);
        repeat (2) @(posedge clk); #1;
        rd(4'd5, d); check("R8 target reached", d, 32'h4);
        check("R10 irq alarm", irq, 1);
        wr(4'd5, 32'h0);
        rd(4'd5, d); check("R9 alarm kept on zero write", d, 32'h4);
        wr(4'd5, 32'h4);
        repeat (3) @(posedge clk); #1;
        rd(4'd5, d); check("R8 no re-arm past target", d, 32'h0);
        check("R10 irq cleared", irq, 0);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_load;
        t_shadow;
        t_rate;
        t_slave;
        t_master;
        t_alarm;
        report;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        report;
    end

endmodule